// File: doc/BRIEF.md
# Interline Frame Readout and Shutter Sequencer

This controller runs one frame of an interline-transfer CCD. A start trigger arms it. It then issues the sequence in a fixed order:

- a substrate shutter pulse, which clears the photodiodes;
- an exposure interval, during which the sensor integrates;
- the photodiode-to-vertical-register transfer pulse;
- one pass per row. Each pass is a two-interval vertical row transfer followed by a line of horizontal clocking.

All durations are counted in a slow timing-unit tick. Voltage generation and per-pixel waveform shaping are done elsewhere.

The horizontal clocks and the charge-multiplier clocks run only during a line. Whenever they are stopped, the first-phase horizontal gates park high and the second-phase gates park low. Each line also carries a black-clamp strobe early in the line.

A bypass mode sends all charge to the low-gain output, so the multiplier stays idle. In bypass mode a reset-low request is raised once per row, during the row transfer.

All programmed lengths are sampled at the accepted trigger and limited to their legal windows.

Top module: `frame_seq_ctrl`

## Requirements
- R1: After reset the block is idle. `busy_o`, `done_o`, `shutter_o`, `vxfer_o`, `vrow_o`, `hrun_o`, `mult_run_o`, `clamp_o` and `rg_low_o` are all low, `h1_o` is high and `h2_o` is low.
- R2: A start accepted while idle raises `shutter_o` in the next cycle.
  - The shutter lasts the programmed shutter length, limited to 20..100 ticks.
  - An exposure interval follows with every pulse output low. It lasts the programmed exposure length, with a minimum of 1 tick.
- R3: After the exposure, `vxfer_o` is high for the programmed transfer length, limited to 30..50 ticks.
- R4: Each row begins with a vertical row transfer on `vrow_o`.
  - Bit 0 is high for the first interval, whose length is limited to 12..20 ticks.
  - Bit 1 is then high for the second interval, whose length is limited to 12..40 ticks.
- R5: After each row transfer, `hrun_o` is high for the column count in ticks. There is one line per row. A row or column count of 0 is treated as 1.
- R6: Whenever the shutter, the transfer pulse or a row transfer is active, `hrun_o` and `mult_run_o` are low.
  - Whenever `hrun_o` is low, `h1_o` is 1 and `h2_o` is 0.
  - During a line, `h1_o` is high on even column indices and `h2_o` is its complement.
- R7: `clamp_o` is high exactly on column indices 2, 3 and 4 of every line, which lies within the first 28 horizontal cycles.
- R8: In bypass mode, `mult_run_o` never rises, and `rg_low_o` is high for the whole second row-transfer interval of every row. Outside bypass mode, `rg_low_o` stays low and `mult_run_o` follows `hrun_o`.
- R9: `busy_o` is high from the cycle after the accepted start until the final tick of the last line. `done_o` pulses for exactly one cycle as `busy_o` falls.
- R10: A start that arrives while busy is ignored. Changes to the configuration inputs after the accepted start do not affect the running frame.
- R11: Every duration advances only on cycles where `tick_i` is high. With no tick, the sequence holds its state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Frame trigger, accepted when idle |
| tick_i | input | 1 | Timing-unit tick enable |
| shut_len_i | input | TIME_W | Shutter length in ticks |
| expo_len_i | input | TIME_W | Exposure length in ticks |
| xfer_len_i | input | TIME_W | Transfer pulse length in ticks |
| tva_len_i | input | TIME_W | First row-transfer interval |
| tvb_len_i | input | TIME_W | Second row-transfer interval |
| rows_i | input | ROW_W | Rows per frame |
| cols_i | input | COL_W | Horizontal cycles per line |
| bypass_i | input | 1 | Route all charge to the low-gain output |
| shutter_o | output | 1 | Substrate shutter pulse |
| vxfer_o | output | 1 | Photodiode transfer pulse |
| vrow_o | output | 2 | Row-transfer interval enables |
| hrun_o | output | 1 | Horizontal clocking enable |
| mult_run_o | output | 1 | Multiplier clocking enable |
| h1_o | output | 1 | First-phase horizontal gate level |
| h2_o | output | 1 | Second-phase horizontal gate level |
| clamp_o | output | 1 | Black-clamp strobe |
| rg_low_o | output | 1 | Reset-gate low request |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | Frame complete pulse |

## Verification
The assertions check the following on every cycle:
- the horizontal and multiplier clocks stay stopped, with the gates parked, during the shutter and the transfers;
- every line is preceded by the second row-transfer interval;
- the clamp lies inside a line;
- the captured configuration and the state hold when there is no tick.

Only the bench's scenarios can show the rest, because each of these needs a whole frame to be counted against arithmetic:
- the exact tick counts of every interval;
- the window limits;
- the line and clamp totals;
- the ignored mid-frame trigger.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

    localparam int DEF_TIME_W = 16;
    localparam int DEF_ROW_W  = 12;
    localparam int DEF_COL_W  = 12;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHUT,
        ST_EXPO,
        ST_XFER,
        ST_TVA,
        ST_TVB,
        ST_LINE
    } fsq_state_e;

    typedef struct packed {
        logic shutter;
        logic vxfer;
        logic tva;
        logic tvb;
        logic hrun;
        logic mult;
        logic clamp;
        logic rg_low;
        logic h1;
        logic h2;
    } fsq_outs_t;

endpackage

// File: rtl/fsq_limit.sv
module fsq_limit #(
    parameter int W  = 16,
    parameter int LO = 1,
    parameter int HI = 100
) (
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] lim_o
);
    localparam logic [W-1:0] LO_V = W'(LO);

    generate
        if (HI >= (2 ** W) - 1) begin : g_lo_only
            assign lim_o = (raw_i < LO_V) ? LO_V : raw_i;
        end else begin : g_both
            localparam logic [W-1:0] HI_V = W'(HI);
            assign lim_o = (raw_i < LO_V) ? LO_V :
                           (raw_i > HI_V) ? HI_V : raw_i;
        end
    endgenerate
endmodule

// File: rtl/fsq_core.sv
module fsq_core
    import fsq_pkg::*;
#(
    parameter int TIME_W = DEF_TIME_W,
    parameter int ROW_W  = DEF_ROW_W,
    parameter int COL_W  = DEF_COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              tick_i,
    input  logic [TIME_W-1:0] shut_len_i,
    input  logic [TIME_W-1:0] expo_len_i,
    input  logic [TIME_W-1:0] xfer_len_i,
    input  logic [TIME_W-1:0] tva_len_i,
    input  logic [TIME_W-1:0] tvb_len_i,
    input  logic [ROW_W-1:0]  rows_i,
    input  logic [COL_W-1:0]  cols_i,
    input  logic              bypass_i,
    output fsq_state_e        state_o,
    output logic [COL_W-1:0]  col_o,
    output logic              bypass_o,
    output logic              done_o
);
    fsq_state_e        state_q;
    logic [TIME_W-1:0] shut_q, expo_q, xfer_q, tva_q, tvb_q, tcnt_q, cur_len;
    logic [ROW_W-1:0]  rows_q, row_q;
    logic [COL_W-1:0]  cols_q, col_q;
    logic              bypass_q, done_q, seg_end;

    always_comb begin
        unique case (state_q)
            ST_SHUT: cur_len = shut_q;
            ST_EXPO: cur_len = expo_q;
            ST_XFER: cur_len = xfer_q;
            ST_TVA:  cur_len = tva_q;
            ST_TVB:  cur_len = tvb_q;
            default: cur_len = '0;
        endcase
    end

    assign seg_end = tick_i && (tcnt_q == cur_len - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            tcnt_q   <= '0;
            row_q    <= '0;
            col_q    <= '0;
            done_q   <= 1'b0;
            shut_q   <= '0;
            expo_q   <= '0;
            xfer_q   <= '0;
            tva_q    <= '0;
            tvb_q    <= '0;
            rows_q   <= '0;
            cols_q   <= '0;
            bypass_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    shut_q   <= shut_len_i;
                    expo_q   <= expo_len_i;
                    xfer_q   <= xfer_len_i;
                    tva_q    <= tva_len_i;
                    tvb_q    <= tvb_len_i;
                    rows_q   <= rows_i;
                    cols_q   <= cols_i;
                    bypass_q <= bypass_i;
                    tcnt_q   <= '0;
                    state_q  <= ST_SHUT;
                end
                ST_SHUT, ST_EXPO, ST_XFER, ST_TVA, ST_TVB: begin
                    if (seg_end) begin
                        tcnt_q <= '0;
                        unique case (state_q)
                            ST_SHUT: state_q <= ST_EXPO;
                            ST_EXPO: state_q <= ST_XFER;
                            ST_XFER: begin
                                state_q <= ST_TVA;
                                row_q   <= '0;
                            end
                            ST_TVA:  state_q <= ST_TVB;
                            default: begin
                                state_q <= ST_LINE;
                                col_q   <= '0;
                            end
                        endcase
                    end else if (tick_i) begin
                        tcnt_q <= tcnt_q + 1'b1;
                    end
                end
                default: if (tick_i) begin
                    if (col_q == cols_q - 1'b1) begin
                        col_q <= '0;
                        if (row_q == rows_q - 1'b1) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            row_q   <= row_q + 1'b1;
                            state_q <= ST_TVA;
                        end
                    end else begin
                        col_q <= col_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign state_o  = state_q;
    assign col_o    = col_q;
    assign bypass_o = bypass_q;
    assign done_o   = done_q;

    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> ($stable(rows_q) && $stable(cols_q) &&
                                  $stable(bypass_q) && $stable(shut_q)));

    // R11
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && state_q != ST_IDLE) |=>
            ($stable(state_q) && $stable(tcnt_q) && $stable(col_q)));
endmodule

// File: rtl/fsq_outdec.sv
module fsq_outdec
    import fsq_pkg::*;
#(
    parameter int COL_W       = DEF_COL_W,
    parameter int CLAMP_START = 2,
    parameter int CLAMP_LEN   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  fsq_state_e       state_i,
    input  logic [COL_W-1:0] col_i,
    input  logic             bypass_i,
    output fsq_outs_t        outs_o
);
    localparam logic [COL_W-1:0] CL_LO = COL_W'(CLAMP_START);
    localparam logic [COL_W-1:0] CL_HI = COL_W'(CLAMP_START + CLAMP_LEN);

    logic line;
    assign line = (state_i == ST_LINE);

    always_comb begin
        outs_o.shutter = (state_i == ST_SHUT);
        outs_o.vxfer   = (state_i == ST_XFER);
        outs_o.tva     = (state_i == ST_TVA);
        outs_o.tvb     = (state_i == ST_TVB);
        outs_o.hrun    = line;
        outs_o.mult    = line && !bypass_i;
        outs_o.clamp   = line && (col_i >= CL_LO) && (col_i < CL_HI);
        outs_o.rg_low  = (state_i == ST_TVB) && bypass_i;
        outs_o.h1      = line ? ~col_i[0] : 1'b1;
        outs_o.h2      = line ?  col_i[0] : 1'b0;
    end

    // R6
    hstop_park_chk: assert property (@(posedge clk) disable iff (rst)
        (outs_o.shutter || outs_o.vxfer || outs_o.tva || outs_o.tvb) |->
            (!outs_o.hrun && !outs_o.mult && outs_o.h1 && !outs_o.h2));

    // R4
    tvb_to_line_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(outs_o.tvb) |-> outs_o.hrun);

    // R5
    line_after_tvb_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(outs_o.hrun) |-> $past(outs_o.tvb));

    // R7
    clamp_in_line_chk: assert property (@(posedge clk) disable iff (rst)
        outs_o.clamp |-> outs_o.hrun);

    // R8
    rg_no_mult_chk: assert property (@(posedge clk) disable iff (rst)
        outs_o.rg_low |-> (!outs_o.mult && outs_o.h1 && !outs_o.h2));
endmodule

// File: rtl/frame_seq_ctrl.sv
module frame_seq_ctrl
    import fsq_pkg::*;
#(
    parameter int TIME_W      = DEF_TIME_W,
    parameter int ROW_W       = DEF_ROW_W,
    parameter int COL_W       = DEF_COL_W,
    parameter int SHUT_MIN    = 20,
    parameter int SHUT_MAX    = 100,
    parameter int XFER_MIN    = 30,
    parameter int XFER_MAX    = 50,
    parameter int TVA_MIN     = 12,
    parameter int TVA_MAX     = 20,
    parameter int TVB_MIN     = 12,
    parameter int TVB_MAX     = 40,
    parameter int CLAMP_START = 2,
    parameter int CLAMP_LEN   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              tick_i,
    input  logic [TIME_W-1:0] shut_len_i,
    input  logic [TIME_W-1:0] expo_len_i,
    input  logic [TIME_W-1:0] xfer_len_i,
    input  logic [TIME_W-1:0] tva_len_i,
    input  logic [TIME_W-1:0] tvb_len_i,
    input  logic [ROW_W-1:0]  rows_i,
    input  logic [COL_W-1:0]  cols_i,
    input  logic              bypass_i,
    output logic              shutter_o,
    output logic              vxfer_o,
    output logic [1:0]        vrow_o,
    output logic              hrun_o,
    output logic              mult_run_o,
    output logic              h1_o,
    output logic              h2_o,
    output logic              clamp_o,
    output logic              rg_low_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int TIME_TOP = (2 ** TIME_W) - 1;
    localparam int ROW_TOP  = (2 ** ROW_W) - 1;
    localparam int COL_TOP  = (2 ** COL_W) - 1;

    logic [TIME_W-1:0] shut_l, expo_l, xfer_l, tva_l, tvb_l;
    logic [ROW_W-1:0]  rows_l;
    logic [COL_W-1:0]  cols_l, col;
    logic              bypass_q;
    fsq_state_e        state;
    fsq_outs_t         outs;

    fsq_limit #(.W(TIME_W), .LO(SHUT_MIN), .HI(SHUT_MAX)) u_lim_shut (.raw_i(shut_len_i), .lim_o(shut_l));
    fsq_limit #(.W(TIME_W), .LO(1),        .HI(TIME_TOP)) u_lim_expo (.raw_i(expo_len_i), .lim_o(expo_l));
    fsq_limit #(.W(TIME_W), .LO(XFER_MIN), .HI(XFER_MAX)) u_lim_xfer (.raw_i(xfer_len_i), .lim_o(xfer_l));
    fsq_limit #(.W(TIME_W), .LO(TVA_MIN),  .HI(TVA_MAX))  u_lim_tva  (.raw_i(tva_len_i),  .lim_o(tva_l));
    fsq_limit #(.W(TIME_W), .LO(TVB_MIN),  .HI(TVB_MAX))  u_lim_tvb  (.raw_i(tvb_len_i),  .lim_o(tvb_l));
    fsq_limit #(.W(ROW_W),  .LO(1),        .HI(ROW_TOP))  u_lim_rows (.raw_i(rows_i),     .lim_o(rows_l));
    fsq_limit #(.W(COL_W),  .LO(1),        .HI(COL_TOP))  u_lim_cols (.raw_i(cols_i),     .lim_o(cols_l));

    fsq_core #(.TIME_W(TIME_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .tick_i     (tick_i),
        .shut_len_i (shut_l),
        .expo_len_i (expo_l),
        .xfer_len_i (xfer_l),
        .tva_len_i  (tva_l),
        .tvb_len_i  (tvb_l),
        .rows_i     (rows_l),
        .cols_i     (cols_l),
        .bypass_i   (bypass_i),
        .state_o    (state),
        .col_o      (col),
        .bypass_o   (bypass_q),
        .done_o     (done_o)
    );

    fsq_outdec #(.COL_W(COL_W), .CLAMP_START(CLAMP_START), .CLAMP_LEN(CLAMP_LEN)) u_dec (
        .clk      (clk),
        .rst      (rst),
        .state_i  (state),
        .col_i    (col),
        .bypass_i (bypass_q),
        .outs_o   (outs)
    );

    assign shutter_o  = outs.shutter;
    assign vxfer_o    = outs.vxfer;
    assign vrow_o     = {outs.tvb, outs.tva};
    assign hrun_o     = outs.hrun;
    assign mult_run_o = outs.mult;
    assign h1_o       = outs.h1;
    assign h2_o       = outs.h2;
    assign clamp_o    = outs.clamp;
    assign rg_low_o   = outs.rg_low;
    assign busy_o     = (state != ST_IDLE);

    // R9
    done_end_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(hrun_o)));

    // R2
    shut_first_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> shutter_o);
endmodule

// File: tb/tb_frame_seq_ctrl.sv
`timescale 1ns/1ps
module tb_frame_seq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_drv = 1'b0, extra_start = 1'b0, tick = 1'b0;
    logic [15:0] shut_d = 16'd25, expo_d = 16'd7, xfer_d = 16'd30, tva_d = 16'd12, tvb_d = 16'd13;
    logic [11:0] rows_d = 12'd1, cols_d = 12'd1;
    logic        byp_d = 1'b0;
    logic        shutter_o, vxfer_o, hrun_o, mult_run_o, h1_o, h2_o, clamp_o, rg_low_o, busy_o, done_o;
    logic [1:0]  vrow_o;

    int checks = 0, fails = 0;
    int tick_mode = 0, tdiv = 0;
    bit clr = 0, inject_en = 0;
    int c_busy, c_shut, c_expo, c_xfer, c_tva, c_tvb, c_hrun, c_lines, c_clamp, c_mult, c_rg, c_viol, c_cviol, c_done;
    int bcol = 0;
    bit prev_h = 0;

    always #2 clk = ~clk;

    frame_seq_ctrl dut (
        .clk(clk), .rst(rst), .start_i(start_drv | extra_start), .tick_i(tick),
        .shut_len_i(shut_d), .expo_len_i(expo_d), .xfer_len_i(xfer_d),
        .tva_len_i(tva_d), .tvb_len_i(tvb_d), .rows_i(rows_d), .cols_i(cols_d),
        .bypass_i(byp_d), .shutter_o(shutter_o), .vxfer_o(vxfer_o), .vrow_o(vrow_o),
        .hrun_o(hrun_o), .mult_run_o(mult_run_o), .h1_o(h1_o), .h2_o(h2_o),
        .clamp_o(clamp_o), .rg_low_o(rg_low_o), .busy_o(busy_o), .done_o(done_o));

    always @(negedge clk) begin
        logic tn;
        case (tick_mode)
            0: tn = 1'b1;
            1: tn = (tdiv == 2);
            default: tn = 1'b0;
        endcase
        tdiv = (tdiv == 2) ? 0 : tdiv + 1;
        tick = tn;
        extra_start = inject_en && busy_o && (c_busy == 10);
        if (clr) begin
            c_busy = 0; c_shut = 0; c_expo = 0; c_xfer = 0; c_tva = 0; c_tvb = 0;
            c_hrun = 0; c_lines = 0; c_clamp = 0; c_mult = 0; c_rg = 0;
            c_viol = 0; c_cviol = 0; c_done = 0; bcol = 0;
        end else begin
            if (tn && busy_o) c_busy++;
            if (tn && shutter_o) c_shut++;
            if (tn && busy_o && !shutter_o && !vxfer_o && vrow_o == 2'b00 && !hrun_o) c_expo++;
            if (tn && vxfer_o) c_xfer++;
            if (tn && vrow_o == 2'b01) c_tva++;
            if (tn && vrow_o == 2'b10) c_tvb++;
            if (tn && hrun_o) c_hrun++;
            if (tn && clamp_o) c_clamp++;
            if (tn && mult_run_o) c_mult++;
            if (tn && rg_low_o) c_rg++;
            if (hrun_o && !prev_h) c_lines++;
            if (done_o) c_done++;
            if (done_o && busy_o) c_viol++;
            if ((shutter_o || vxfer_o || vrow_o != 2'b00) && (hrun_o || mult_run_o)) c_viol++;
            if (!hrun_o && !(h1_o && !h2_o)) c_viol++;
            if (hrun_o) begin
                if (h1_o != ((bcol % 2) == 0) || h2_o == h1_o) c_viol++;
                if (clamp_o != (bcol >= 2 && bcol < 5)) c_cviol++;
                if (tn) bcol++;
            end else begin
                bcol = 0;
                if (clamp_o) c_cviol++;
            end
        end
        prev_h = hrun_o;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lim(input int v, input int lo, input int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    task automatic run_frame(input int rows, input int cols, input int shut, input int expo,
                             input int xfer, input int tva, input int tvb, input bit byp,
                             input int mode, input bit inject, input bit hold);
        int er = (rows < 1) ? 1 : rows;
        int ec = (cols < 1) ? 1 : cols;
        int ls = lim(shut, 20, 100);
        int le = (expo < 1) ? 1 : expo;
        int lx = lim(xfer, 30, 50);
        int la = lim(tva, 12, 20);
        int lb = lim(tvb, 12, 40);
        int cw = ((ec < 5) ? ec : 5) - 2;
        int n = 0;
        if (cw < 0) cw = 0;
        @(posedge clk); #1;
        rows_d = 12'(rows); cols_d = 12'(cols); shut_d = 16'(shut); expo_d = 16'(expo);
        xfer_d = 16'(xfer); tva_d = 16'(tva); tvb_d = 16'(tvb); byp_d = byp;
        tick_mode = hold ? 2 : mode; inject_en = inject;
        start_drv = 1'b1; clr = 1'b1;
        @(posedge clk); #1;
        start_drv = 1'b0; clr = 1'b0;
        if (inject) begin
            rows_d = 12'd5; cols_d = 12'd9; byp_d = ~byp; shut_d = 16'd99; tvb_d = 16'd33;
        end
        if (hold) begin
            repeat (30) @(posedge clk);
            #1;
            chk("R11 shutter held without tick", int'(shutter_o), 1);
            chk("R11 no ticks consumed", c_busy, 0);
            tick_mode = mode;
        end
        while (c_done == 0 && n < 20000) begin
            @(posedge clk); n++;
        end
        repeat (4) @(posedge clk);
        #1;
        inject_en = 0;
        if (n >= 20000) chk("R9 frame completion watchdog", 0, 1);
        chk("R2 shutter ticks", c_shut, ls);
        chk("R2 exposure ticks", c_expo, le);
        chk("R3 transfer ticks", c_xfer, lx);
        chk("R4 first interval ticks", c_tva, er * la);
        chk("R4 second interval ticks", c_tvb, er * lb);
        chk("R5 line count", c_lines, er);
        chk("R5 horizontal ticks", c_hrun, er * ec);
        chk("R6 stop and park violations", c_viol, 0);
        chk("R7 clamp position errors", c_cviol, 0);
        chk("R7 clamp ticks", c_clamp, er * cw);
        chk("R8 multiplier ticks", c_mult, byp ? 0 : er * ec);
        chk("R8 reset-low ticks", c_rg, byp ? er * lb : 0);
        chk("R9 busy ticks", c_busy, ls + le + lx + er * (la + lb + ec));
        chk("R9 done pulses", c_done, 1);
        chk("R9 idle after frame", int'(busy_o), 0);
        if (inject) chk("R10 restart ignored, config kept", c_busy, ls + le + lx + er * (la + lb + ec));
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int cl[3] = '{1, 3, 6};
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R1 busy", int'(busy_o), 0);
        chk("R1 pulses", int'({shutter_o, vxfer_o, vrow_o, hrun_o, mult_run_o, clamp_o, rg_low_o, done_o}), 0);
        chk("R1 park levels", int'({h1_o, h2_o}), 2);
        for (int r = 1; r <= 3; r++)
            for (int c = 0; c < 3; c++)
                for (int b = 0; b < 2; b++)
                    run_frame(r, cl[c], 25, 7, 30, 12, 13, b[0], (r + c) % 2, 0, 0);
        run_frame(0, 0, 3, 0, 0, 100, 5, 0, 0, 0, 0);
        run_frame(2, 8, 500, 3, 200, 15, 100, 1, 1, 0, 0);
        run_frame(2, 4, 30, 5, 40, 14, 20, 0, 0, 1, 0);
        run_frame(1, 6, 22, 2, 35, 13, 12, 1, 0, 0, 1);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule